// File: doc/BRIEF.md
# Processor-to-I/O Address Translating Bridge

This block sits between a processor request port and a 16-bit-addressed I/O bus. A processor access that falls inside an 8 MB window starting at 0x80000000 is turned into one I/O bus request. The window offset becomes a 16-bit I/O address in one of two layouts, chosen by a map-select input. In the contiguous layout the low 16 offset bits are used directly. In the non-contiguous layout the address is rebuilt from two separate offset fields. An access outside the window is never forwarded. It completes at once and reads back all ones.

With the big-endian parameter set, the bridge reorders bytes according to the access size. This applies both to write data going out and to read data coming back. Only one transaction is in flight at a time: the processor port stops accepting requests until the I/O side acknowledges. The map-select input is captured when a request is taken, so it may change freely while a transfer is pending.

Top module: `iobr_bridge`

## Requirements
- R1: While reset is held, `cpu_req_ready` is 1, and `io_req_valid` and `cpu_rsp_valid` are 0.
- R2: A request accepted (valid and ready high at a clock edge) with address 0x80000000 to 0x807FFFFF inclusive drives `io_req_valid` high from the next cycle. In that cycle `io_size` and `io_wr` carry the accepted size code and write flag. The size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes.
- R3: With `map_noncontig` = 0 at acceptance, `io_addr` equals bits 15:0 of the address.
- R4: With `map_noncontig` = 1 at acceptance, `io_addr` bits 4:0 equal address bits 4:0, and `io_addr` bits 15:5 equal address bits 22:12.
- R5: A change of `map_noncontig` after acceptance does not alter `io_addr` of the pending request.
- R6: From the cycle after an in-window acceptance until the cycle after `io_ack`, `cpu_req_ready` is 0. During that time `io_req_valid`, `io_addr` and `io_wdata` hold steady.
- R7: The cycle after `io_ack` is seen with a request pending, `cpu_rsp_valid` is 1 for one cycle with the returned read data, `io_req_valid` is 0, and `cpu_req_ready` is 1.
- R8: For size code 0, write data reaches `io_wdata` unchanged, and `io_rdata` reaches `cpu_rdata` unchanged.
- R9: For size code 1 (big-endian), the two low bytes of write and read data are exchanged and the two upper bytes pass unchanged.
- R10: For size code 2 (big-endian), all four bytes of write and read data are reversed (byte 0 with byte 3, byte 1 with byte 2).
- R11: An accepted request outside the window raises no I/O request. In the next cycle `cpu_rsp_valid` is 1 and `cpu_rdata` is 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Bridge can take a request |
| cpu_addr | input | 32 | Processor byte address |
| cpu_size | input | 2 | Access size code (0:1 B, 1:2 B, 2:4 B) |
| cpu_wr | input | 1 | 1 for write, 0 for read |
| cpu_wdata | input | 32 | Write data, processor lane order |
| cpu_rsp_valid | output | 1 | Completion pulse |
| cpu_rdata | output | 32 | Read data, valid with the completion |
| map_noncontig | input | 1 | 0 contiguous layout, 1 non-contiguous layout |
| io_req_valid | output | 1 | I/O request pending |
| io_addr | output | 16 | Translated I/O address |
| io_size | output | 2 | Access size code on the I/O side |
| io_wr | output | 1 | I/O write flag |
| io_wdata | output | 32 | Write data, I/O lane order |
| io_ack | input | 1 | I/O side completes the pending request |
| io_rdata | input | 32 | I/O read data, valid with `io_ack` |

## Verification
Two functions can meet in one cycle. A completion pulse for a finished transfer can coincide with acceptance of the next request. A change of the map select can coincide with the edge that accepts a request. The bench chains transfers so that each new request is presented in the very cycle the previous response appears. It also toggles the map select both at the accept edge and while a request waits for its acknowledge. A behavioural reference model predicts ready, the I/O request fields and the response on every clock. A response lost to the overlap, or an address built from the wrong layout, shows up as a mismatch in that cycle.

// File: rtl/iobr_pkg.sv
package iobr_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    // number of bytes an access of this size spans, clamped to the bus width
    function automatic int unsigned span_bytes(size_e sz, int unsigned lanes);
        int unsigned n;
        n = 1 << sz;
        return (n > lanes) ? lanes : n;
    endfunction

endpackage

// File: rtl/iobr_addr_xlate.sv
module iobr_addr_xlate #(
    parameter int                AW        = 32,
    parameter int                WIN_AW    = 23,
    parameter int                IO_AW     = 16,
    parameter int                LOW_BITS  = 5,
    parameter int                HIGH_LSB  = 12,
    parameter logic [AW-1:0]     BASE_ADDR = 32'h8000_0000
) (
    input  logic [AW-1:0]    addr,
    input  logic             noncontig,
    output logic             hit,
    output logic [IO_AW-1:0] io_addr
);
    localparam logic [WIN_AW-1:0] LOW_MASK = WIN_AW'((1 << LOW_BITS) - 1);

    logic [WIN_AW-1:0] offset;
    logic [WIN_AW-1:0] upper_field;
    logic [WIN_AW-1:0] split_addr;

    always_comb begin
        hit         = (addr[AW-1:WIN_AW] == BASE_ADDR[AW-1:WIN_AW]);
        offset      = addr[WIN_AW-1:0];
        upper_field = (offset >> HIGH_LSB) << LOW_BITS;
        split_addr  = upper_field | (offset & LOW_MASK);
        io_addr     = noncontig ? split_addr[IO_AW-1:0] : offset[IO_AW-1:0];
    end

endmodule

// File: rtl/iobr_lane_swap.sv
module iobr_lane_swap #(
    parameter int DW         = 32,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  iobr_pkg::size_e  size,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout
);
    localparam int unsigned LANES = DW / 8;

    generate
        if (BIG_ENDIAN) begin : g_reorder
            always_comb begin
                int unsigned span;
                span = iobr_pkg::span_bytes(size, LANES);
                for (int unsigned i = 0; i < LANES; i++) begin
                    if (i < span)
                        dout[i*8 +: 8] = din[(span-1-i)*8 +: 8];
                    else
                        dout[i*8 +: 8] = din[i*8 +: 8];
                end
            end
        end else begin : g_pass
            assign dout = din;
        end
    endgenerate

endmodule

// File: rtl/iobr_bridge.sv
module iobr_bridge #(
    parameter int            AW         = 32,
    parameter int            DW         = 32,
    parameter int            WIN_AW     = 23,
    parameter int            IO_AW      = 16,
    parameter int            LOW_BITS   = 5,
    parameter int            HIGH_LSB   = 12,
    parameter logic [AW-1:0] BASE_ADDR  = 32'h8000_0000,
    parameter bit            BIG_ENDIAN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_req_valid,
    output logic             cpu_req_ready,
    input  logic [AW-1:0]    cpu_addr,
    input  logic [1:0]       cpu_size,
    input  logic             cpu_wr,
    input  logic [DW-1:0]    cpu_wdata,
    output logic             cpu_rsp_valid,
    output logic [DW-1:0]    cpu_rdata,
    input  logic             map_noncontig,
    output logic             io_req_valid,
    output logic [IO_AW-1:0] io_addr,
    output logic [1:0]       io_size,
    output logic             io_wr,
    output logic [DW-1:0]    io_wdata,
    input  logic             io_ack,
    input  logic [DW-1:0]    io_rdata
);
    import iobr_pkg::*;

    typedef struct packed {
        logic             busy;
        logic             rsp;
        logic [DW-1:0]    rdata;
        logic [IO_AW-1:0] addr;
        size_e            size;
        logic             wr;
        logic [DW-1:0]    wdata;
    } regs_t;

    regs_t q, d;

    logic             win_hit;
    logic [IO_AW-1:0] xl_addr;
    logic [DW-1:0]    wdata_lanes;
    logic [DW-1:0]    rdata_lanes;

    iobr_addr_xlate #(
        .AW(AW), .WIN_AW(WIN_AW), .IO_AW(IO_AW),
        .LOW_BITS(LOW_BITS), .HIGH_LSB(HIGH_LSB), .BASE_ADDR(BASE_ADDR)
    ) u_xlate (
        .addr      (cpu_addr),
        .noncontig (map_noncontig),
        .hit       (win_hit),
        .io_addr   (xl_addr)
    );

    iobr_lane_swap #(.DW(DW), .BIG_ENDIAN(BIG_ENDIAN)) u_wr_swap (
        .size (size_e'(cpu_size)),
        .din  (cpu_wdata),
        .dout (wdata_lanes)
    );

    iobr_lane_swap #(.DW(DW), .BIG_ENDIAN(BIG_ENDIAN)) u_rd_swap (
        .size (q.size),
        .din  (io_rdata),
        .dout (rdata_lanes)
    );

    always_comb begin
        d     = q;
        d.rsp = 1'b0;
        if (q.busy) begin
            if (io_ack) begin
                d.busy  = 1'b0;
                d.rsp   = 1'b1;
                d.rdata = rdata_lanes;
            end
        end else if (cpu_req_valid) begin
            if (win_hit) begin
                d.busy  = 1'b1;
                d.addr  = xl_addr;
                d.size  = size_e'(cpu_size);
                d.wr    = cpu_wr;
                d.wdata = wdata_lanes;
            end else begin
                d.rsp   = 1'b1;
                d.rdata = '1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cpu_req_ready = !q.busy;
    assign cpu_rsp_valid = q.rsp;
    assign cpu_rdata     = q.rdata;
    assign io_req_valid  = q.busy;
    assign io_addr       = q.addr;
    assign io_size       = q.size;
    assign io_wr         = q.wr;
    assign io_wdata      = q.wdata;

    // R2
    fwd_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready &&
         cpu_addr[AW-1:WIN_AW] == BASE_ADDR[AW-1:WIN_AW])
        |=> (io_req_valid && !cpu_req_ready && io_size == $past(cpu_size)));

    // R6
    hold_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req_valid && !io_ack)
        |=> (io_req_valid && $stable(io_addr) && $stable(io_wdata)));

    // R7
    ack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req_valid && io_ack)
        |=> (cpu_rsp_valid && !io_req_valid && cpu_req_ready));

    // R11
    miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready &&
         cpu_addr[AW-1:WIN_AW] != BASE_ADDR[AW-1:WIN_AW])
        |=> (cpu_rsp_valid && cpu_rdata == '1 && !io_req_valid));

    // R7
    rsp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |-> ($past(io_ack && io_req_valid) ||
                           $past(cpu_req_valid && cpu_req_ready)));

endmodule

// File: tb/tb_iobr_bridge.sv
module tb_iobr_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic [31:0] cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic        cpu_wr = 1'b0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_rsp_valid;
    logic [31:0] cpu_rdata;
    logic        map_noncontig = 1'b0;
    logic        io_req_valid;
    logic [15:0] io_addr;
    logic [1:0]  io_size;
    logic        io_wr;
    logic [31:0] io_wdata;
    logic        io_ack = 1'b0;
    logic [31:0] io_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit flip_active = 1'b0;

    always #4 clk = ~clk;

    iobr_bridge dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rsp_valid(cpu_rsp_valid),
        .cpu_rdata(cpu_rdata), .map_noncontig(map_noncontig),
        .io_req_valid(io_req_valid), .io_addr(io_addr), .io_size(io_size),
        .io_wr(io_wr), .io_wdata(io_wdata), .io_ack(io_ack),
        .io_rdata(io_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic logic [31:0] ref_lanes(input logic [31:0] v, input logic [1:0] sz);
        case (sz)
            2'd0:    return v;
            2'd1:    return {v[31:16], v[7:0], v[15:8]};
            default: return {v[7:0], v[15:8], v[23:16], v[31:24]};
        endcase
    endfunction

    function automatic logic [15:0] ref_xl(input logic [31:0] a, input logic m);
        longint off;
        off = a % 32'h0080_0000;
        if (m) return 16'((off % 32) + (off / 4096) * 32);
        return 16'(off % 65536);
    endfunction

    function automatic string size_tag(input logic [1:0] sz);
        case (sz)
            2'd0:    return "R8";
            2'd1:    return "R9";
            default: return "R10";
        endcase
    endfunction

    // reference model state, valid for the current cycle
    bit          m_busy, m_rsp, m_miss, m_mode, m_wr;
    logic [15:0] m_addr;
    logic [1:0]  m_size;
    logic [31:0] m_wdata, m_rdata;

    always @(negedge clk) begin
        cycles++;
        if (!rst_n) begin
            chk("R1 ready", 32'(cpu_req_ready), 32'd1);
            chk("R1 io_req_valid", 32'(io_req_valid), 32'd0);
            chk("R1 rsp_valid", 32'(cpu_rsp_valid), 32'd0);
            m_busy = 0; m_rsp = 0; m_miss = 0; m_mode = 0; m_wr = 0;
            m_addr = '0; m_size = '0; m_wdata = '0; m_rdata = '0;
        end else begin
            chk("R6 ready", 32'(cpu_req_ready), 32'(!m_busy));
            chk("R2 io_req_valid", 32'(io_req_valid), 32'(m_busy));
            chk(m_miss ? "R11 rsp_valid" : "R7 rsp_valid", 32'(cpu_rsp_valid), 32'(m_rsp));
            if (m_busy) begin
                chk(flip_active ? "R5 io_addr" : (m_mode ? "R4 io_addr" : "R3 io_addr"),
                    32'(io_addr), 32'(m_addr));
                chk("R2 io_size", 32'(io_size), 32'(m_size));
                chk("R2 io_wr", 32'(io_wr), 32'(m_wr));
                chk({size_tag(m_size), " io_wdata"}, io_wdata, m_wdata);
            end
            if (m_rsp)
                chk(m_miss ? "R11 rdata" : {size_tag(m_size), " rdata"}, cpu_rdata, m_rdata);
            // advance the model with this cycle's inputs
            m_rsp = 0;
            if (m_busy) begin
                if (io_ack) begin
                    m_busy = 0; m_rsp = 1; m_miss = 0;
                    m_rdata = ref_lanes(io_rdata, m_size);
                end
            end else if (cpu_req_valid) begin
                if (cpu_addr >= 32'h8000_0000 && cpu_addr <= 32'h807F_FFFF) begin
                    m_busy = 1; m_mode = map_noncontig; m_wr = cpu_wr;
                    m_size = cpu_size;
                    m_addr = ref_xl(cpu_addr, map_noncontig);
                    m_wdata = ref_lanes(cpu_wdata, cpu_size);
                end else begin
                    m_rsp = 1; m_miss = 1; m_rdata = 32'hFFFF_FFFF;
                end
            end
        end
    end

    // called at 1 time unit after a rising edge; returns at the same phase
    task automatic xfer(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                        input logic [31:0] wd, input logic mp, input int lat,
                        input logic [31:0] rd, input bit flip);
        bit hit;
        hit = (a >= 32'h8000_0000 && a <= 32'h807F_FFFF);
        cpu_req_valid = 1; cpu_addr = a; cpu_size = sz; cpu_wr = wr;
        cpu_wdata = wd; map_noncontig = mp;
        @(posedge clk); #1;
        cpu_req_valid = 0;
        if (hit) begin
            flip_active = flip;
            for (int k = 0; k < lat; k++) begin
                if (flip) map_noncontig = ~map_noncontig;
                @(posedge clk); #1;
            end
            io_ack = 1; io_rdata = rd;
            @(posedge clk); #1;
            io_ack = 0; io_rdata = 32'hDEAD_BEEF;
            flip_active = 0;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1;
        idle(1);
        // R8 byte write and read, contiguous layout (R3)
        xfer(32'h8000_0092, 2'd0, 1, 32'h1234_5601, 0, 2, 32'h0, 0);
        idle(1);
        xfer(32'h8000_0800, 2'd0, 0, 32'h0, 0, 1, 32'hAABB_CCEF, 0);
        // R9 halfword accesses
        xfer(32'h8001_2346, 2'd1, 1, 32'h5566_A1B2, 0, 0, 32'h0, 0);
        xfer(32'h8000_03F4, 2'd1, 0, 32'h0, 0, 3, 32'h7788_1234, 0);
        // R10 word accesses
        xfer(32'h8040_1F08, 2'd2, 1, 32'h0102_0304, 0, 1, 32'h0, 0);
        xfer(32'h8000_0CF8, 2'd2, 0, 32'h0, 0, 2, 32'hCAFE_F00D, 0);
        idle(2);
        // R4 non-contiguous layout
        xfer(32'h8012_3414, 2'd2, 0, 32'h0, 1, 1, 32'h1122_3344, 0);
        xfer(32'h807F_F01F, 2'd0, 1, 32'h0000_00A5, 1, 0, 32'h0, 0);
        xfer(32'h8000_0FE0, 2'd1, 0, 32'h0, 1, 2, 32'h0000_BEEF, 0);
        // R5 map toggled while pending
        xfer(32'h8055_5AAA, 2'd2, 1, 32'hA0B0_C0D0, 1, 4, 32'h0, 1);
        xfer(32'h8033_3333, 2'd1, 0, 32'h0, 0, 3, 32'h0000_4321, 1);
        // R11 out-of-window, including both window edges
        xfer(32'h7FFF_FFFF, 2'd2, 0, 32'h0, 0, 0, 32'h0, 0);
        xfer(32'h8080_0000, 2'd0, 1, 32'h55, 1, 0, 32'h0, 0);
        xfer(32'h0000_0000, 2'd1, 0, 32'h0, 0, 0, 32'h0, 0);
        xfer(32'h807F_FFFF, 2'd0, 0, 32'h0, 1, 1, 32'h0000_0099, 0);
        xfer(32'h8000_0000, 2'd2, 0, 32'h0, 0, 0, 32'h8765_4321, 0);
        xfer(32'hFFFF_FFF0, 2'd2, 1, 32'h1, 0, 0, 32'h0, 0);
        // R6 back-to-back chain with a request in every response cycle
        for (int j = 0; j < 24; j++)
            xfer(32'h8000_0000 + 32'(j * 32'h0001_1235), 2'(j % 3), j[0],
                 32'h9000_0000 + 32'(j * 32'h0101_0101), j[1], j % 4,
                 32'h0F1E_2D3C ^ 32'(j * 32'h0011_0011), j[2]);
        idle(3);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        while (cycles < 20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule